// File: doc/BRIEF.md
# Carry-Select Adder with Sectioned Speculation

This combinational adder sums two operands and a carry-in, and returns the sum, the unsigned carry-out and a signed overflow flag. The operands are cut into 4-bit sections, and the default width of 16 bits gives four sections. The width may be any multiple of four.

Each section holds two small ripple adders. These adders use bit-level generate and propagate terms, so the carry into bit k+1 is g(k) OR (p(k) AND carry into bit k). One adder assumes an incoming carry of 0 and the other assumes 1. Both results are ready before the real carry arrives. The real carry then passes only through one 2:1 selection per section, which picks the matching sum nibble and section carry-out. The external carry-in drives the lowest section.

The block suits any datapath that needs a shorter carry path than a full ripple adder without a full lookahead tree.

Top module: `csel_adder`

## Requirements
- R1: `sum` equals (`op_a` + `op_b` + `carry_in`) modulo 2^WIDTH for all operand values.
- R2: `carry_out` equals bit WIDTH of the full-precision value `op_a` + `op_b` + `carry_in`.
- R3: `overflow` is 1 exactly when `op_a` and `op_b` have equal most significant bits and the most significant bit of `sum` differs from them.
- R4: With `carry_in` = 1, the result is one greater than the result with `carry_in` = 0 for the same operands.
- R5: A carry created in the lowest section reaches `carry_out` through every section. For example, all-ones plus zero with `carry_in` = 1 gives `sum` = 0 and `carry_out` = 1.
- R6: Each 4-bit section selects the precomputed result whose assumed carry matches the carry leaving the section below it. For example, 0x000F + 0x0001 gives 0x0010, and 0x0FFF + 0x0001 gives 0x1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top bit |
| overflow | output | 1 | Two's-complement overflow |

## Verification
The bench goes after section boundaries: operands whose carry leaves nibble 0, 1 or 2. A design that selects with the wrong carry, or with the carry-in polarity swapped, gets the upper nibbles wrong by exactly one.

The all-ones-plus-carry case exercises the whole selection chain. A break anywhere in that chain leaves `carry_out` at 0 or leaves stray ones in the sum.

Signed-limit operands such as 0x7FFF+1, 0x8000+0x8000 and 0x8000+0xFFFF separate overflow from carry-out. A design that flags overflow from the carry alone, or from the wrong bit, fails these cases.

// File: rtl/csel_pkg.sv
package csel_pkg;
    localparam int SEG_W = 4;

    typedef struct packed {
        logic [SEG_W-1:0] p;
        logic [SEG_W-1:0] g;
    } pg_t;

    typedef struct packed {
        logic [SEG_W-1:0] sum;
        logic             cout;
        logic             c_top;   // carry into the section's top bit
    } seg_res_t;

    function automatic pg_t make_pg(input logic [SEG_W-1:0] x, input logic [SEG_W-1:0] y);
        pg_t r;
        r.p = x ^ y;
        r.g = x & y;
        return r;
    endfunction
endpackage

// File: rtl/csel_spec_seg.sv
module csel_spec_seg
    import csel_pkg::*;
#(
    parameter bit ASSUME_C = 1'b0
) (
    input  pg_t      pg,
    output seg_res_t res
);
    logic [SEG_W:0] c;

    always_comb begin
        c[0] = ASSUME_C;
        for (int k = 0; k < SEG_W; k++) begin
            c[k+1]     = pg.g[k] | (pg.p[k] & c[k]);
            res.sum[k] = pg.p[k] ^ c[k];
        end
        res.cout  = c[SEG_W];
        res.c_top = c[SEG_W-1];
    end
endmodule

// File: rtl/csel_section.sv
module csel_section
    import csel_pkg::*;
(
    input  logic [SEG_W-1:0] a_seg,
    input  logic [SEG_W-1:0] b_seg,
    input  logic             carry_in,
    output logic [SEG_W-1:0] sum_seg,
    output logic             cout_seg,
    output logic             ctop_seg
);
    pg_t      pg;
    seg_res_t spec [2];
    seg_res_t pick;

    assign pg = make_pg(a_seg, b_seg);

    for (genvar h = 0; h < 2; h++) begin : g_hyp
        csel_spec_seg #(.ASSUME_C(h == 1)) u_spec (
            .pg  (pg),
            .res (spec[h])
        );
    end

    assign pick     = carry_in ? spec[1] : spec[0];
    assign sum_seg  = pick.sum;
    assign cout_seg = pick.cout;
    assign ctop_seg = pick.c_top;

    always_comb begin
        AST_SPEC_STEP: assert ({spec[1].cout, spec[1].sum} == {spec[0].cout, spec[0].sum} + 1'b1)
            else $error("speculative results not one apart"); // R4
        AST_SPEC_ORDER: assert (!spec[0].cout || spec[1].cout)
            else $error("carry with cin=0 but not with cin=1"); // R6
        AST_SECTION_SUM: assert ({cout_seg, sum_seg} == {1'b0, a_seg} + {1'b0, b_seg} + {{SEG_W{1'b0}}, carry_in})
            else $error("section picked wrong hypothesis"); // R6
    end
endmodule

// File: rtl/csel_adder.sv
module csel_adder
    import csel_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             overflow
);
    localparam int NSEG = WIDTH / SEG_W;

    logic [NSEG:0]   chain;
    logic [NSEG-1:0] ctop;

    assign chain[0] = carry_in;

    for (genvar s = 0; s < NSEG; s++) begin : g_sec
        csel_section u_sec (
            .a_seg    (op_a[s*SEG_W +: SEG_W]),
            .b_seg    (op_b[s*SEG_W +: SEG_W]),
            .carry_in (chain[s]),
            .sum_seg  (sum[s*SEG_W +: SEG_W]),
            .cout_seg (chain[s+1]),
            .ctop_seg (ctop[s])
        );
    end

    assign carry_out = chain[NSEG];
    assign overflow  = ctop[NSEG-1] ^ chain[NSEG];

    always_comb begin
        AST_WIDE_SUM: assert ({carry_out, sum} == {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in})
            else $error("sum or carry mismatch"); // R1 R2
        AST_OVF_SIGN: assert (overflow == ((op_a[WIDTH-1] == op_b[WIDTH-1]) && (sum[WIDTH-1] != op_a[WIDTH-1])))
            else $error("overflow flag wrong"); // R3
    end
endmodule

// File: tb/csel_adder_tb.sv
module csel_adder_tb;
    localparam int W = 16;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         ci;
        logic [W-1:0] e_sum;
        logic         e_co;
        logic         e_ov;
        string        tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic carry_in = 1'b0;
    logic [W-1:0] sum;
    logic carry_out, overflow;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    item_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    csel_adder #(.WIDTH(W)) u_dut (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .sum(sum), .carry_out(carry_out), .overflow(overflow)
    );

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci, input string tag);
        item_t it;
        logic [W:0] full;
        @(posedge clk);
        op_a = a; op_b = b; carry_in = ci;
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        it.a = a; it.b = b; it.ci = ci;
        it.e_sum = full[W-1:0];
        it.e_co  = full[W];
        it.e_ov  = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
        it.tag = tag;
        sb.push_back(it);
    endtask

    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            item_t it;
            bit bad;
            it = sb.pop_front();
            n_vec++;
            bad = 1'b0;
            if (sum !== it.e_sum) begin
                $display("FAIL %s/R1 sum a=%h b=%h ci=%b: got %h exp %h", it.tag, it.a, it.b, it.ci, sum, it.e_sum);
                bad = 1'b1;
            end
            if (carry_out !== it.e_co) begin
                $display("FAIL %s/R2 carry_out a=%h b=%h ci=%b: got %b exp %b", it.tag, it.a, it.b, it.ci, carry_out, it.e_co);
                bad = 1'b1;
            end
            if (overflow !== it.e_ov) begin
                $display("FAIL %s/R3 overflow a=%h b=%h ci=%b: got %b exp %b", it.tag, it.a, it.b, it.ci, overflow, it.e_ov);
                bad = 1'b1;
            end
            if (bad) n_bad++;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        rst = 1'b0;
        drive(16'h0000, 16'h0000, 1'b0, "R1 zero");
        drive(16'h0000, 16'h0000, 1'b1, "R4 cin only");
        drive(16'h1234, 16'h4321, 1'b0, "R4 base");
        drive(16'h1234, 16'h4321, 1'b1, "R4 plus one");
        drive(16'hFFFF, 16'h0000, 1'b1, "R5 full chain");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R5 all ones");
        drive(16'h000F, 16'h0001, 1'b0, "R6 nibble0");
        drive(16'h00FF, 16'h0001, 1'b0, "R6 nibble1");
        drive(16'h0FFF, 16'h0001, 1'b0, "R6 nibble2");
        drive(16'h0F0F, 16'h00F0, 1'b1, "R6 alt");
        drive(16'h7FFF, 16'h0001, 1'b0, "R3 pos ovf");
        drive(16'h8000, 16'h8000, 1'b0, "R3 neg ovf");
        drive(16'h8000, 16'hFFFF, 1'b0, "R3 neg ovf2");
        drive(16'h7FFF, 16'h8000, 1'b1, "R3 mixed");
        for (int i = 0; i < 300; i++)
            drive(W'($urandom), W'($urandom), 1'($urandom), "R1 random");
        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule